// File: doc/BRIEF.md
# Dual Lockstep Output Comparator

This block sits between two identical processor cores that run the same program in lockstep and the system bus they share. On every clock it compares the two cores' address, write-data, write-enable and control outputs. When they agree, core A's outputs are passed to the bus with their enables asserted. When any of them differs, the bus enables are dropped in that same cycle and the block leaves normal operation.

Once it has left normal operation, the block first writes a fault record into a small log FIFO. The record holds the cycle number, the address from each core and a bit mask of the signal groups that disagreed. It then holds both cores in reset for a programmable number of cycles. After releasing them, it waits one cycle for their outputs to agree. If they agree, normal operation resumes. If they do not, the attempt counts as a failed recovery and the log-and-reset sequence repeats. After a set number of consecutive failed recoveries, a permanent fail output latches, and the cores stay in reset until the block itself is reset.

Top module: `lockstep_cmp`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the block is in normal operation: `in_err` = 0, `perm_fail` = 0, `core_rst_n` = 1, `log_valid` = 0 and `log_ovf` = 0.
- R2: In normal operation, when the two cores agree, `bus_oe` is 1 in the same cycle. `bus_addr`, `bus_wdata` and `bus_ctrl` carry core A's values, and `bus_data_oe` equals core A's write enable.
- R3: In normal operation, any difference in address, control or write enable drives `bus_oe` and `bus_data_oe` to 0 in the same cycle. `in_err` reads 1 from the next cycle on.
- R4: Write data is compared only when both write enables are 1. Differing data with either enable low causes no fault.
- R5: Each fault writes one log record. The record holds the cycle counter value at detection (the number of clock edges since reset release), both cores' addresses, and `log_mask` with bit 0 = address, bit 1 = write enable, bit 2 = data and bit 3 = control. The record is visible on the log outputs after the second rising edge following detection.
- R6: The log returns records oldest first. `log_pop` while `log_valid` = 1 removes the head record at the clock edge.
- R7: A record that arrives while the log holds LOG_DEPTH records (and no pop occurs in that cycle) is dropped, and `log_ovf` sets and stays set until reset.
- R8: After logging, `core_rst_n` is 0 for max(`rst_len`, 1) cycles. Then one synchronisation cycle follows with the bus off. If the cores agree in that cycle, normal operation (`in_err` = 0, `bus_oe` live) resumes at the next edge.
- R9: A mismatch in the synchronisation cycle is a failed recovery and is logged. Once MAX_FAIL consecutive failures have been logged, `perm_fail` latches to 1, `core_rst_n` stays 0 and `bus_oe` stays 0 until reset.
- R10: A successful resynchronisation clears the failed-recovery count, so failures that are not consecutive never reach permanent fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_len | input | RST_CYC_W | Number of cycles to hold the cores in reset during recovery |
| a_addr | input | ADDR_W | Core A address |
| a_wdata | input | DATA_W | Core A write data |
| a_wen | input | 1 | Core A write-data enable |
| a_ctrl | input | CTRL_W | Core A control outputs |
| b_addr | input | ADDR_W | Core B address |
| b_wdata | input | DATA_W | Core B write data |
| b_wen | input | 1 | Core B write-data enable |
| b_ctrl | input | CTRL_W | Core B control outputs |
| bus_addr | output | ADDR_W | Address to bus |
| bus_wdata | output | DATA_W | Write data to bus |
| bus_ctrl | output | CTRL_W | Control to bus |
| bus_oe | output | 1 | Address/control drive enable |
| bus_data_oe | output | 1 | Write-data drive enable |
| core_rst_n | output | 1 | Active-low reset to both cores |
| in_err | output | 1 | Block is in error/recovery mode |
| perm_fail | output | 1 | Permanent failure latched |
| log_pop | input | 1 | Remove head log record |
| log_valid | output | 1 | Log holds at least one record |
| log_cycle | output | CNT_W | Head record: cycle of detection |
| log_addr_a | output | ADDR_W | Head record: core A address |
| log_addr_b | output | ADDR_W | Head record: core B address |
| log_mask | output | 4 | Head record: mismatch mask |
| log_ovf | output | 1 | Sticky log overflow |

## Verification
A wrong comparator shows up in the same cycle, as `bus_oe` being wrong for the presented core outputs. A wrong recovery state shows up over a few cycles, in the length of the `core_rst_n` low pulse, in the cycle at which `in_err` clears, or in `perm_fail` latching too early or too late. Log faults show up two edges after detection, in the head record's mask, addresses and cycle value, and in the order of the records and the overflow flag once records are popped.

// File: rtl/lockstep_pkg.sv
// Shared definitions for the lockstep comparator.
// Assumes: the mask bit positions below are the external encoding of log_mask.
package lockstep_pkg;

    localparam int MASK_W  = 4;
    localparam int MB_ADDR = 0;
    localparam int MB_WEN  = 1;
    localparam int MB_DATA = 2;
    localparam int MB_CTRL = 3;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_LOG  = 3'd1,
        ST_HOLD = 3'd2,
        ST_SYNC = 3'd3,
        ST_DEAD = 3'd4
    } lsc_state_e;

endpackage

// File: rtl/lsc_compare.sv
// Purely combinational comparison of the two cores' outputs.
// Produces a per-group disagreement mask; data is compared only while both
// write enables are active, so undriven data does not cause a fault.
module lsc_compare #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CTRL_W = 4
) (
    input  logic [ADDR_W-1:0]                  a_addr,
    input  logic [DATA_W-1:0]                  a_wdata,
    input  logic                               a_wen,
    input  logic [CTRL_W-1:0]                  a_ctrl,
    input  logic [ADDR_W-1:0]                  b_addr,
    input  logic [DATA_W-1:0]                  b_wdata,
    input  logic                               b_wen,
    input  logic [CTRL_W-1:0]                  b_ctrl,
    output logic [lockstep_pkg::MASK_W-1:0]    diff_mask,
    output logic                               mismatch
);
    import lockstep_pkg::*;

    // Build one disagreement flag per signal group.
    always_comb begin
        diff_mask          = '0;
        diff_mask[MB_ADDR] = (a_addr != b_addr);
        diff_mask[MB_WEN]  = (a_wen != b_wen);
        diff_mask[MB_DATA] = a_wen && b_wen && (a_wdata != b_wdata);
        diff_mask[MB_CTRL] = (a_ctrl != b_ctrl);
    end

    // Any flagged group is a fault.
    assign mismatch = |diff_mask;

endmodule

// File: rtl/lsc_recover.sv
// Error-mode sequencer: log, hold cores in reset, resynchronise, or give up.
// Assumes mismatch is only meaningful in RUN and SYNC; rst_len is sampled
// in the LOG state. Failures are counted only when resynchronisation fails.
module lsc_recover #(
    parameter int RST_CYC_W = 8,
    parameter int MAX_FAIL  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mismatch,
    input  logic [RST_CYC_W-1:0] rst_len,
    output logic                 run_mode,
    output logic                 capture,
    output logic                 push,
    output logic                 core_rst_n,
    output logic                 in_err,
    output logic                 perm_fail
);
    import lockstep_pkg::*;

    localparam int FAIL_W = (MAX_FAIL > 0) ? $clog2(MAX_FAIL + 1) : 1;
    localparam logic [FAIL_W-1:0] FAIL_LIM = FAIL_W'(MAX_FAIL);

    lsc_state_e           state;
    logic [RST_CYC_W-1:0] hold_cnt;
    logic [FAIL_W-1:0]    fails;

    // State, hold counter and failed-recovery counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            hold_cnt <= '0;
            fails    <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (mismatch) state <= ST_LOG;
                end
                ST_LOG: begin
                    hold_cnt <= rst_len;
                    if (fails == FAIL_LIM) state <= ST_DEAD;
                    else                   state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (hold_cnt <= RST_CYC_W'(1)) state <= ST_SYNC;
                    else hold_cnt <= hold_cnt - 1'b1;
                end
                ST_SYNC: begin
                    if (mismatch) begin
                        fails <= fails + 1'b1;
                        state <= ST_LOG;
                    end else begin
                        fails <= '0;
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_DEAD;
            endcase
        end
    end

    // Decode outputs from the current state.
    always_comb begin
        run_mode   = (state == ST_RUN);
        capture    = ((state == ST_RUN) || (state == ST_SYNC)) && mismatch;
        push       = (state == ST_LOG);
        core_rst_n = !((state == ST_HOLD) || (state == ST_DEAD));
        in_err     = (state != ST_RUN);
        perm_fail  = (state == ST_DEAD);
    end

endmodule

// File: rtl/lsc_logfifo.sv
// Small first-in first-out store for fault records.
// A push into a full store (with no pop in the same cycle) is dropped and
// sets a sticky overflow flag. The head record is presented combinationally.
module lsc_logfifo #(
    parameter int WIDTH = 52,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             valid,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Accepted operations for this cycle.
    always_comb begin
        do_pop  = pop && (count != '0);
        do_push = push && ((count != FULL_C) || do_pop);
    end

    // Record storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && !do_push) ovf <= 1'b1;
        end
    end

    // Head record.
    assign dout  = mem[rd_ptr];
    assign valid = (count != '0);

endmodule

// File: rtl/lockstep_cmp.sv
// Top level of the dual lockstep output comparator.
// Passes core A outputs to the bus only while both cores agree; on a
// disagreement disables the bus at once, logs the fault and runs recovery.
// Assumes both cores share clk and are reset together through core_rst_n.
module lockstep_cmp #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CTRL_W     = 4,
    parameter int CNT_W      = 16,
    parameter int RST_CYC_W  = 8,
    parameter int LOG_DEPTH  = 4,
    parameter int MAX_FAIL   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RST_CYC_W-1:0] rst_len,
    input  logic [ADDR_W-1:0]    a_addr,
    input  logic [DATA_W-1:0]    a_wdata,
    input  logic                 a_wen,
    input  logic [CTRL_W-1:0]    a_ctrl,
    input  logic [ADDR_W-1:0]    b_addr,
    input  logic [DATA_W-1:0]    b_wdata,
    input  logic                 b_wen,
    input  logic [CTRL_W-1:0]    b_ctrl,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    output logic [CTRL_W-1:0]    bus_ctrl,
    output logic                 bus_oe,
    output logic                 bus_data_oe,
    output logic                 core_rst_n,
    output logic                 in_err,
    output logic                 perm_fail,
    input  logic                 log_pop,
    output logic                 log_valid,
    output logic [CNT_W-1:0]     log_cycle,
    output logic [ADDR_W-1:0]    log_addr_a,
    output logic [ADDR_W-1:0]    log_addr_b,
    output logic [3:0]           log_mask,
    output logic                 log_ovf
);
    import lockstep_pkg::*;

    localparam int REC_W = CNT_W + 2 * ADDR_W + MASK_W;

    logic [MASK_W-1:0] diff_mask;
    logic              mismatch;
    logic              run_mode, capture, push;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [REC_W-1:0]  rec_q, rec_head;

    lsc_compare #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
    ) u_cmp (
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wen(a_wen), .a_ctrl(a_ctrl),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wen(b_wen), .b_ctrl(b_ctrl),
        .diff_mask(diff_mask), .mismatch(mismatch)
    );

    lsc_recover #(
        .RST_CYC_W(RST_CYC_W), .MAX_FAIL(MAX_FAIL)
    ) u_rec (
        .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .rst_len(rst_len),
        .run_mode(run_mode), .capture(capture), .push(push),
        .core_rst_n(core_rst_n), .in_err(in_err), .perm_fail(perm_fail)
    );

    // Free-running cycle counter used to time-stamp faults.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_cnt <= '0;
        else        cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Hold the fault record from the detection cycle until it is logged.
    always_ff @(posedge clk) begin
        if (!rst_n)       rec_q <= '0;
        else if (capture) rec_q <= {cyc_cnt, a_addr, b_addr, diff_mask};
    end

    lsc_logfifo #(
        .WIDTH(REC_W), .DEPTH(LOG_DEPTH)
    ) u_log (
        .clk(clk), .rst_n(rst_n), .push(push), .din(rec_q),
        .pop(log_pop), .dout(rec_head), .valid(log_valid), .ovf(log_ovf)
    );

    // Split the head record into its fields.
    assign {log_cycle, log_addr_a, log_addr_b, log_mask} = rec_head;

    // Bus drive: core A values, enabled only while running and agreeing.
    always_comb begin
        bus_addr    = a_addr;
        bus_wdata   = a_wdata;
        bus_ctrl    = a_ctrl;
        bus_oe      = run_mode && !mismatch;
        bus_data_oe = run_mode && !mismatch && a_wen;
    end

endmodule

// File: rtl/lockstep_cmp_chk.sv
// Property checker for lockstep_cmp, attached with bind.
// Observes ports only; all properties are disabled during reset.
module lockstep_cmp_chk #(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [ADDR_W-1:0] b_addr,
    input logic [CTRL_W-1:0] a_ctrl,
    input logic [CTRL_W-1:0] b_ctrl,
    input logic              bus_oe,
    input logic              bus_data_oe,
    input logic              core_rst_n,
    input logic              in_err,
    input logic              perm_fail,
    input logic              log_ovf
);
    // R3
    err_blocks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |-> !bus_oe);

    // R3
    addr_diff_enters_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_err && (a_addr != b_addr || a_ctrl != b_ctrl)) |=> in_err);

    // R2
    data_oe_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> bus_oe);

    // R8
    core_reset_blocks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> (!bus_oe && in_err));

    // R9
    perm_fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_fail |=> (perm_fail && !core_rst_n));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_ovf |=> log_ovf);

endmodule

bind lockstep_cmp lockstep_cmp_chk #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .b_addr(b_addr),
    .a_ctrl(a_ctrl), .b_ctrl(b_ctrl), .bus_oe(bus_oe),
    .bus_data_oe(bus_data_oe), .core_rst_n(core_rst_n), .in_err(in_err),
    .perm_fail(perm_fail), .log_ovf(log_ovf)
);

// File: tb/lockstep_cmp_tb.sv
module lockstep_cmp_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rst_len = 8'd2;
    logic [15:0] a_addr = '0, b_addr = '0, a_wdata = '0, b_wdata = '0;
    logic        a_wen = 1'b0, b_wen = 1'b0;
    logic [3:0]  a_ctrl = '0, b_ctrl = '0;
    logic [15:0] bus_addr, bus_wdata;
    logic [3:0]  bus_ctrl;
    logic        bus_oe, bus_data_oe, core_rst_n, in_err, perm_fail;
    logic        log_pop = 1'b0, log_valid, log_ovf;
    logic [15:0] log_cycle, log_addr_a, log_addr_b;
    logic [3:0]  log_mask;

    int checks = 0, errors = 0;
    logic [15:0] tb_cyc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockstep_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .rst_len(rst_len),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wen(a_wen), .a_ctrl(a_ctrl),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wen(b_wen), .b_ctrl(b_ctrl),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ctrl(bus_ctrl),
        .bus_oe(bus_oe), .bus_data_oe(bus_data_oe), .core_rst_n(core_rst_n),
        .in_err(in_err), .perm_fail(perm_fail), .log_pop(log_pop),
        .log_valid(log_valid), .log_cycle(log_cycle), .log_addr_a(log_addr_a),
        .log_addr_b(log_addr_b), .log_mask(log_mask), .log_ovf(log_ovf)
    );

    // Bench model of "edges since reset release" for the time stamp.
    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= '0;
        else        tb_cyc <= tb_cyc + 16'd1;
    end

    typedef struct packed {
        logic [15:0] aa, ba;
        logic        awe, bwe;
        logic [15:0] ad, bd;
        logic [3:0]  ac, bc;
        logic        ok;
        logic [3:0]  mask;
    } vec_t;

    // mask: bit0 addr, bit1 write enable, bit2 data, bit3 control
    localparam vec_t TBL [8] = '{
        '{16'h1000, 16'h1000, 1'b1, 1'b1, 16'hA5A5, 16'hA5A5, 4'h3, 4'h3, 1'b1, 4'h0},
        '{16'h1004, 16'h1004, 1'b0, 1'b0, 16'h1111, 16'h2222, 4'h2, 4'h2, 1'b1, 4'h0},
        '{16'h2000, 16'h2001, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h1, 4'h1, 1'b0, 4'h1},
        '{16'h3000, 16'h3000, 1'b1, 1'b0, 16'h5555, 16'h5555, 4'h1, 4'h1, 1'b0, 4'h2},
        '{16'h4000, 16'h4000, 1'b1, 1'b1, 16'h0F0F, 16'h0F0E, 4'h1, 4'h1, 1'b0, 4'h4},
        '{16'h5000, 16'h5000, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h8, 4'h9, 1'b0, 4'h8},
        '{16'h6000, 16'h7000, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'h4, 4'h5, 1'b0, 4'h9},
        '{16'h8000, 16'h8000, 1'b1, 1'b0, 16'h1234, 16'h4321, 4'h2, 4'h2, 1'b0, 4'h2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t v);
        a_addr = v.aa; b_addr = v.ba; a_wen = v.awe; b_wen = v.bwe;
        a_wdata = v.ad; b_wdata = v.bd; a_ctrl = v.ac; b_ctrl = v.bc;
    endtask

    task automatic drive_agree();
        a_addr = 16'h0100; b_addr = 16'h0100; a_wen = 1'b0; b_wen = 1'b0;
        a_wdata = '0; b_wdata = '0; a_ctrl = 4'h1; b_ctrl = 4'h1;
    endtask

    task automatic drive_fault(input logic [15:0] aa);
        drive_agree();
        a_addr = aa; b_addr = 16'hFFFF;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive_agree();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Waits until the cores have been put in reset and released again;
    // returns at the first negedge of the synchronisation cycle.
    task automatic wait_release();
        int n = 0;
        while (core_rst_n !== 1'b0 && n < 60) begin @(negedge clk); n++; end
        while (core_rst_n !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    endtask

    task automatic pop_one();
        log_pop = 1'b1;
        @(negedge clk);
        log_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hold_n;
        logic [15:0] exp_cyc;

        // ---- R1: reset state
        @(negedge clk);
        do_reset();
        #1;
        check("R1 in_err", in_err, 0);
        check("R1 perm_fail", perm_fail, 0);
        check("R1 core_rst_n", core_rst_n, 1);
        check("R1 log_valid", log_valid, 0);
        check("R1 log_ovf", log_ovf, 0);

        // ---- Table walk: R2, R3, R4, R5, R8
        rst_len = 8'd2;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drive_vec(TBL[i]);
            exp_cyc = tb_cyc;
            #1;
            check("R2/R3 bus_oe", bus_oe, TBL[i].ok);
            if (TBL[i].ok) begin
                check("R2 bus_addr", bus_addr, TBL[i].aa);
                check("R2 bus_wdata", bus_wdata, TBL[i].ad);
                check("R2 bus_data_oe", bus_data_oe, TBL[i].awe);
                @(negedge clk);
                #1 check("R4 no fault", in_err, 0);
            end else begin
                check("R3 bus_data_oe off", bus_data_oe, 0);
                @(negedge clk);
                drive_agree();
                #1;
                check("R3 in_err", in_err, 1);
                check("R3 bus_oe off", bus_oe, 0);
                @(negedge clk);
                #1;
                check("R5 log_valid", log_valid, 1);
                check("R5 log_mask", log_mask, TBL[i].mask);
                check("R5 log_addr_a", log_addr_a, TBL[i].aa);
                check("R5 log_addr_b", log_addr_b, TBL[i].ba);
                check("R5 log_cycle", log_cycle, exp_cyc);
                wait_release();
                #1 check("R8 sync bus off", bus_oe, 0);
                @(negedge clk);
                #1;
                check("R8 resumed in_err", in_err, 0);
                check("R8 resumed bus_oe", bus_oe, 1);
                pop_one();
                #1 check("R6 popped", log_valid, 0);
            end
        end

        // ---- R8: reset hold length for rst_len 3 and 0
        for (int k = 0; k < 2; k++) begin
            rst_len = (k == 0) ? 8'd3 : 8'd0;
            @(negedge clk);
            drive_fault(16'h0A0A);
            @(negedge clk);
            drive_agree();
            hold_n = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (core_rst_n === 1'b0) hold_n++;
                else if (hold_n > 0) break;
            end
            check("R8 hold cycles", hold_n, (k == 0) ? 3 : 1);
            @(negedge clk);
            pop_one();
        end

        // ---- R6, R7: ordering and overflow
        do_reset();
        rst_len = 8'd1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            drive_fault(16'(k + 1));
            @(negedge clk);
            drive_agree();
            wait_release();
            @(negedge clk);
            #1;
            if (k == 3) check("R7 no overflow at depth", log_ovf, 0);
            if (k == 4) check("R7 overflow set", log_ovf, 1);
        end
        for (int j = 0; j < 4; j++) begin
            #1 check("R6 order valid", log_valid, 1);
            check("R6 order addr", log_addr_a, 16'(j + 1));
            pop_one();
        end
        #1 check("R6 empty after pops", log_valid, 0);
        check("R7 overflow still set", log_ovf, 1);

        // ---- R9: permanent fail after consecutive failed recoveries
        do_reset();
        rst_len = 8'd1;
        @(negedge clk);
        drive_fault(16'h0BAD);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (perm_fail === 1'b1) break;
        end
        #1;
        check("R9 perm_fail", perm_fail, 1);
        check("R9 core held", core_rst_n, 0);
        check("R9 bus off", bus_oe, 0);
        drive_agree();
        repeat (5) @(negedge clk);
        #1 check("R9 perm_fail sticky", perm_fail, 1);
        hold_n = 0;
        for (int c = 0; c < 8; c++) begin
            if (log_valid === 1'b1) begin
                hold_n++;
                pop_one();
                #1;
            end
        end
        check("R9 logged attempts", hold_n, 4);
        do_reset();
        #1 check("R1 perm_fail cleared", perm_fail, 0);

        // ---- R10: non-consecutive failures do not latch
        rst_len = 8'd1;
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            drive_fault(16'h0C0C);
            @(negedge clk);
            drive_agree();
            for (int f = 0; f < 2; f++) begin
                wait_release();
                drive_fault(16'h0D0D);
                @(negedge clk);
                drive_agree();
            end
            wait_release();
            @(negedge clk);
            #1 check("R10 resumed", in_err, 0);
        end
        check("R10 no perm_fail", perm_fail, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule